// File: doc/BRIEF.md
# Four-Valued Controlled-Gate Cascade Evaluator

This block evaluates a stored cascade of reversible gates on a small register of lines. Each line holds one of four values: the Boolean values 0 and 1, and the two intermediate values v0 and v1 that a square-root-of-NOT step produces. The block supports four gate kinds. An unconditional inversion applies to one line. A controlled inversion, a controlled V step and a controlled inverse-V step each take one control line and one target line.

A host first builds the gate list by presenting one gate per cycle on the load port. It can empty the list with the clear input. It then writes a Boolean input assignment to the lines and pulses start. The block applies exactly one gate per clock cycle, in load order. While it runs, the lines are visible as they change. One cycle after the last gate it pulses done. At that point the outputs show the final line values, the number of gates applied as a unit-cost figure, and a sticky flag. The flag reports whether any control line held a non-Boolean value during the run.

Top module: `ncv_cascade_sim`

## Requirements
- R1: Each line value is encoded in 2 bits: 0=00, v0=01, 1=10, v1=11. Line i appears at line_vals[2i+1:2i]. Reset makes every line 0, and cost, busy, done and ctrl_err low. An input load while idle sets line i to 1 (10) when in_bits[i] is 1, and to 0 (00) otherwise.
- R2: Gate op code 00 (inversion) ignores its control field and adds 2 mod 4 to its target unconditionally, so 0↔1 and v0↔v1.
- R3: Op code 01 (controlled inversion) adds 2 mod 4 to the target when the control line is 1. It leaves the target unchanged when the control line is 0.
- R4: Op code 10 (controlled V) adds 1 mod 4 to the target when the control line is 1 (0→v0→1→v1→0). Two such gates in a row on the same target equal one inversion.
- R5: Op code 11 (controlled inverse V) subtracts 1 mod 4 from the target when the control line is 1. A V gate followed by an inverse-V gate on the same target restores the target's value.
- R6: When a controlled gate (op code 01, 10 or 11) meets a control line that holds v0 or v1, ctrl_err is set and stays set until the next accepted start. The target is left unchanged, and the following gates still run.
- R7: After start, gate k of the list (counting from 0) is applied at clock edge k+1. cost rises by exactly one for every gate applied, starting from 0. done is high for exactly the one cycle after the last gate, and busy is then low.
- R8: A gate load is rejected in two cases. The first is a controlled gate whose control index equals its target index. The second is a load when the list already holds MAX_GATES gates.
- R9: Start with an empty list raises done on the next cycle with cost 0. The lines are left unchanged.
- R10: While busy, gate loads, list clears, input loads and further starts are all ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_load | input | 1 | Append the presented gate to the list |
| gate_op | input | 2 | Gate kind: 00 inversion, 01 controlled inversion, 10 controlled V, 11 controlled inverse V |
| gate_ctrl | input | LINE_W | Control line index (unused by op 00) |
| gate_tgt | input | LINE_W | Target line index |
| gate_clear | input | 1 | Empty the gate list |
| in_load | input | 1 | Write the Boolean input assignment to the lines |
| in_bits | input | N_LINES | Input assignment, one bit per line |
| start | input | 1 | Begin evaluating the list |
| line_vals | output | 2*N_LINES | Current line values, 2 bits per line |
| cost | output | CNT_W | Gates applied in the current or last run |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle pulse after the last gate |
| ctrl_err | output | 1 | Sticky: a control line held v0 or v1 |

## Verification
The assertions assume the host does not change the gate list between the start cycle and the done pulse. The host-side gating guarantees this. They also assume that a non-Boolean control value can only arise from a V or inverse-V step earlier in the same run. The stimulus never issues start in the same cycle as a load or a clear. It loads lines only with Boolean values. It drives non-Boolean controls on purpose only in the error scenario. A behavioural model in the bench compares every line, cost, busy, done and ctrl_err on every clock.

// File: rtl/ncv_pkg.sv
package ncv_pkg;

    typedef enum logic [1:0] {
        OP_NOT  = 2'b00,
        OP_CNOT = 2'b01,
        OP_CV   = 2'b10,
        OP_CVDG = 2'b11
    } ncv_op_e;

    localparam logic [1:0] VAL_ZERO = 2'b00;
    localparam logic [1:0] VAL_V0   = 2'b01;
    localparam logic [1:0] VAL_ONE  = 2'b10;
    localparam logic [1:0] VAL_V1   = 2'b11;

    // The two Boolean codes have a clear low bit.
    function automatic logic is_boolean(logic [1:0] v);
        return v[0] == 1'b0;
    endfunction

    // The action a firing gate applies to its target, modulo 4.
    function automatic logic [1:0] gate_action(ncv_op_e op, logic [1:0] v);
        case (op)
            OP_NOT, OP_CNOT: return v + 2'd2;
            OP_CV:           return v + 2'd1;
            default:         return v - 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/ncv_gate_store.sv
module ncv_gate_store
    import ncv_pkg::*;
#(
    parameter int N_LINES   = 4,
    parameter int MAX_GATES = 16,
    localparam int LINE_W = (N_LINES > 1) ? $clog2(N_LINES) : 1,
    localparam int ADDR_W = (MAX_GATES > 1) ? $clog2(MAX_GATES) : 1,
    localparam int CNT_W  = $clog2(MAX_GATES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  ncv_op_e           wr_op,
    input  logic [LINE_W-1:0] wr_ctrl,
    input  logic [LINE_W-1:0] wr_tgt,
    input  logic [ADDR_W-1:0] rd_addr,
    output ncv_op_e           rd_op,
    output logic [LINE_W-1:0] rd_ctrl,
    output logic [LINE_W-1:0] rd_tgt,
    output logic [CNT_W-1:0]  count
);

    typedef struct packed {
        ncv_op_e           op;
        logic [LINE_W-1:0] ctrl;
        logic [LINE_W-1:0] tgt;
    } gate_t;

    typedef struct packed {
        gate_t [MAX_GATES-1:0] mem;
        logic  [CNT_W-1:0]     cnt;
    } store_t;

    store_t st_d, st_q;
    logic   self_loop;
    gate_t  rd_gate;

    always_comb begin
        st_d      = st_q;
        self_loop = (wr_op != OP_NOT) && (wr_ctrl == wr_tgt);
        if (clear) begin
            st_d.cnt = '0;
        end else if (wr_en && !self_loop && (st_q.cnt < CNT_W'(MAX_GATES))) begin
            st_d.mem[st_q.cnt[ADDR_W-1:0]] = '{op: wr_op, ctrl: wr_ctrl, tgt: wr_tgt};
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_gate = st_q.mem[rd_addr];
    assign rd_op   = rd_gate.op;
    assign rd_ctrl = rd_gate.ctrl;
    assign rd_tgt  = rd_gate.tgt;
    assign count   = st_q.cnt;

    AST_NO_SELF_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (CNT_W'(rd_addr) < count && rd_op != OP_NOT) |-> (rd_ctrl != rd_tgt)); // R8

    AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(MAX_GATES)); // R8

endmodule

// File: rtl/ncv_gate_eval.sv
module ncv_gate_eval
    import ncv_pkg::*;
#(
    parameter int N_LINES = 4,
    localparam int LINE_W = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic [N_LINES-1:0][1:0] lines_in,
    input  ncv_op_e                 op,
    input  logic [LINE_W-1:0]       ctrl,
    input  logic [LINE_W-1:0]       tgt,
    output logic [N_LINES-1:0][1:0] lines_out,
    output logic                    ctrl_bad
);

    logic [1:0] ctrl_val;
    logic       fire;

    always_comb begin
        ctrl_val = lines_in[ctrl];
        ctrl_bad = (op != OP_NOT) && !is_boolean(ctrl_val);
        fire     = (op == OP_NOT) || (ctrl_val == VAL_ONE);
    end

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        assign lines_out[i] = (fire && tgt == LINE_W'(i)) ? gate_action(op, lines_in[i])
                                                          : lines_in[i];
    end

endmodule

// File: rtl/ncv_cascade_sim.sv
module ncv_cascade_sim
    import ncv_pkg::*;
#(
    parameter int N_LINES   = 4,
    parameter int MAX_GATES = 16,
    localparam int LINE_W = (N_LINES > 1) ? $clog2(N_LINES) : 1,
    localparam int ADDR_W = (MAX_GATES > 1) ? $clog2(MAX_GATES) : 1,
    localparam int CNT_W  = $clog2(MAX_GATES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 gate_load,
    input  logic [1:0]           gate_op,
    input  logic [LINE_W-1:0]    gate_ctrl,
    input  logic [LINE_W-1:0]    gate_tgt,
    input  logic                 gate_clear,
    input  logic                 in_load,
    input  logic [N_LINES-1:0]   in_bits,
    input  logic                 start,
    output logic [2*N_LINES-1:0] line_vals,
    output logic [CNT_W-1:0]     cost,
    output logic                 busy,
    output logic                 done,
    output logic                 ctrl_err
);

    typedef struct packed {
        logic                    busy;
        logic                    done;
        logic                    err;
        logic [ADDR_W-1:0]       idx;
        logic [CNT_W-1:0]        cost;
        logic [N_LINES-1:0][1:0] lines;
    } run_t;

    run_t s_d, s_q;

    ncv_op_e                 cur_op;
    logic [LINE_W-1:0]       cur_ctrl, cur_tgt;
    logic [CNT_W-1:0]        gate_count;
    logic [N_LINES-1:0][1:0] ev_lines;
    logic                    ev_bad;

    ncv_gate_store #(.N_LINES(N_LINES), .MAX_GATES(MAX_GATES)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (gate_clear && !s_q.busy),
        .wr_en   (gate_load && !s_q.busy),
        .wr_op   (ncv_op_e'(gate_op)),
        .wr_ctrl (gate_ctrl),
        .wr_tgt  (gate_tgt),
        .rd_addr (s_q.idx),
        .rd_op   (cur_op),
        .rd_ctrl (cur_ctrl),
        .rd_tgt  (cur_tgt),
        .count   (gate_count)
    );

    ncv_gate_eval #(.N_LINES(N_LINES)) eval_i (
        .lines_in  (s_q.lines),
        .op        (cur_op),
        .ctrl      (cur_ctrl),
        .tgt       (cur_tgt),
        .lines_out (ev_lines),
        .ctrl_bad  (ev_bad)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (s_q.busy) begin
            s_d.lines = ev_lines;
            s_d.err   = s_q.err | ev_bad;
            s_d.cost  = s_q.cost + 1'b1;
            if (CNT_W'(s_q.idx) == gate_count - 1'b1) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end else begin
                s_d.idx = s_q.idx + 1'b1;
            end
        end else begin
            if (in_load) begin
                for (int i = 0; i < N_LINES; i++)
                    s_d.lines[i] = in_bits[i] ? VAL_ONE : VAL_ZERO;
            end
            if (start) begin
                s_d.err  = 1'b0;
                s_d.cost = '0;
                s_d.idx  = '0;
                if (gate_count == '0) s_d.done = 1'b1;
                else                  s_d.busy = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign line_vals = s_q.lines;
    assign cost      = s_q.cost;
    assign busy      = s_q.busy;
    assign done      = s_q.done;
    assign ctrl_err  = s_q.err;

    AST_COST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (cost == $past(cost) + 1'b1)); // R7

    AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && gate_count != '0) |-> ($fell(busy) && cost == gate_count)); // R7

    AST_ERR_ON_BAD_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ev_bad) |=> ctrl_err); // R6

    AST_BAD_CTRL_HOLDS_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ev_bad) |=> $stable(line_vals)); // R6

    AST_LIST_FROZEN_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(gate_count)); // R10

    AST_EMPTY_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !in_load && gate_count == '0) |=> (done && cost == '0 && $stable(line_vals))); // R9

endmodule

// File: tb/ncv_cascade_sim_tb_top.sv
`timescale 1ns/1ps
module ncv_cascade_sim_tb_top;

    localparam int NL   = 4;
    localparam int MAXG = 16;
    localparam int LW   = 2;
    localparam int CW   = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          gate_load = 0, gate_clear = 0, in_load = 0, start = 0;
    logic [1:0]    gate_op = 0;
    logic [LW-1:0] gate_ctrl = 0, gate_tgt = 0;
    logic [NL-1:0] in_bits = 0;
    logic [2*NL-1:0] line_vals;
    logic [CW-1:0] cost;
    logic          busy, done, ctrl_err;

    int checks = 0;
    int failures = 0;
    bit cmp_en = 0;
    bit reported = 0;

    always #2.5 clk = ~clk;

    ncv_cascade_sim #(.N_LINES(NL), .MAX_GATES(MAXG)) dut_i (
        .clk(clk), .rst_n(rst_n), .gate_load(gate_load), .gate_op(gate_op),
        .gate_ctrl(gate_ctrl), .gate_tgt(gate_tgt), .gate_clear(gate_clear),
        .in_load(in_load), .in_bits(in_bits), .start(start),
        .line_vals(line_vals), .cost(cost), .busy(busy), .done(done), .ctrl_err(ctrl_err)
    );

    // Behavioural reference model: values 0=0, v0=1, 1=2, v1=3
    int q_op[$], q_c[$], q_t[$];
    int m_line[NL];
    int m_cost, m_idx;
    bit m_busy, m_done, m_err;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_err = 0; m_cost = 0; m_idx = 0;
            foreach (m_line[i]) m_line[i] = 0;
            q_op.delete(); q_c.delete(); q_t.delete();
        end else begin
            m_done = 0;
            if (m_busy) begin
                int op, c, t, cv;
                op = q_op[m_idx]; c = q_c[m_idx]; t = q_t[m_idx];
                cv = m_line[c];
                if (op == 0) m_line[t] = (m_line[t] + 2) % 4;
                else if (cv == 1 || cv == 3) m_err = 1;
                else if (cv == 2) begin
                    if (op == 1)      m_line[t] = (m_line[t] + 2) % 4;
                    else if (op == 2) m_line[t] = (m_line[t] + 1) % 4;
                    else              m_line[t] = (m_line[t] + 3) % 4;
                end
                m_cost++;
                if (m_idx == q_op.size() - 1) begin m_busy = 0; m_done = 1; end
                else m_idx++;
            end else begin
                if (gate_clear) begin
                    q_op.delete(); q_c.delete(); q_t.delete();
                end else if (gate_load) begin
                    if (!(gate_op != 0 && gate_ctrl == gate_tgt) && q_op.size() < MAXG) begin
                        q_op.push_back(int'(gate_op));
                        q_c.push_back(int'(gate_ctrl));
                        q_t.push_back(int'(gate_tgt));
                    end
                end
                if (in_load) foreach (m_line[i]) m_line[i] = in_bits[i] ? 2 : 0;
                if (start) begin
                    m_err = 0; m_cost = 0; m_idx = 0;
                    if (q_op.size() == 0) m_done = 1; else m_busy = 1;
                end
            end
        end
    end

    function automatic logic [2*NL-1:0] model_vals();
        logic [2*NL-1:0] v;
        for (int i = 0; i < NL; i++) v[2*i +: 2] = 2'(m_line[i]);
        return v;
    endfunction

    task automatic chk(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R1", int'(line_vals), int'(model_vals()), "cycle line_vals");
            chk("R7", int'(cost), m_cost, "cycle cost");
            chk("R7", int'(busy), int'(m_busy), "cycle busy");
            chk("R7", int'(done), int'(m_done), "cycle done");
            chk("R6", int'(ctrl_err), int'(m_err), "cycle ctrl_err");
        end
    end

    task automatic load_gate(int op, int c, int t);
        @(negedge clk);
        gate_load = 1; gate_op = 2'(op); gate_ctrl = LW'(c); gate_tgt = LW'(t);
        @(negedge clk);
        gate_load = 0;
    endtask

    task automatic clear_list();
        @(negedge clk); gate_clear = 1;
        @(negedge clk); gate_clear = 0;
    endtask

    task automatic set_inputs(int bits);
        @(negedge clk); in_load = 1; in_bits = NL'(bits);
        @(negedge clk); in_load = 0;
    endtask

    task automatic run_and_wait();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        for (int k = 0; k < 100 && !done; k++) @(negedge clk);
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #100000;
        failures++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", int'(line_vals), 0, "reset lines");
        chk("R1", int'({cost, busy, done, ctrl_err}), 0, "reset flags");
        rst_n = 1;
        @(negedge clk);
        cmp_en = 1;

        // R2: inversion, control field ignored
        load_gate(0, 0, 0); load_gate(0, 3, 0); load_gate(0, 1, 3);
        set_inputs(4'b0000);
        run_and_wait();
        chk("R2", int'(line_vals), 'h80, "inversions");
        chk("R7", int'(cost), 3, "cost after 3 gates");
        chk("R7", int'(done), 1, "done pulse");

        // R3: controlled inversion, fires on 1, holds on 0
        clear_list();
        load_gate(1, 0, 1); load_gate(1, 2, 3);
        set_inputs(4'b0001);
        run_and_wait();
        chk("R3", int'(line_vals), 'h0A, "controlled inversion");

        // R4: two V steps equal inversion; one V gives v0
        clear_list();
        load_gate(2, 0, 1); load_gate(2, 0, 1); load_gate(2, 0, 2);
        set_inputs(4'b0001);
        run_and_wait();
        chk("R4", int'(line_vals), 'h1A, "V steps");

        // R5: inverse V undoes V; from 0 gives v1
        clear_list();
        load_gate(2, 0, 1); load_gate(3, 0, 1); load_gate(3, 0, 2);
        set_inputs(4'b0001);
        run_and_wait();
        chk("R5", int'(line_vals), 'h32, "inverse V");

        // R6: non-Boolean control sets sticky error, target held
        clear_list();
        load_gate(2, 0, 1); load_gate(1, 1, 2); load_gate(0, 0, 3);
        set_inputs(4'b0001);
        run_and_wait();
        chk("R6", int'(line_vals), 'h86, "bad control holds target");
        chk("R6", int'(ctrl_err), 1, "error set");
        repeat (2) @(negedge clk);
        chk("R6", int'(ctrl_err), 1, "error sticky");

        // R8: self-target rejection and full list
        clear_list();
        load_gate(1, 1, 1); load_gate(2, 2, 2); load_gate(0, 1, 1);
        for (int k = 0; k < 16; k++) load_gate(0, 0, 0);
        set_inputs(4'b0000);
        run_and_wait();
        chk("R8", int'(cost), 16, "accepted gate count");
        chk("R8", int'(line_vals), 'h0A, "full list result");
        chk("R6", int'(ctrl_err), 0, "error cleared by start");

        // R9: empty list
        clear_list();
        set_inputs(4'b0101);
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        chk("R9", int'(done), 1, "empty done next cycle");
        chk("R9", int'(cost), 0, "empty cost");
        chk("R9", int'(line_vals), 'h22, "empty lines unchanged");

        // R10: loads and starts ignored while busy
        load_gate(0, 0, 0); load_gate(0, 0, 0); load_gate(0, 0, 0);
        set_inputs(4'b0000);
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        in_load = 1; in_bits = 4'b1111; gate_load = 1; gate_op = 0; gate_tgt = 1;
        @(negedge clk);
        in_load = 0; gate_load = 0; start = 1; gate_clear = 1;
        @(negedge clk);
        start = 0; gate_clear = 0;
        for (int k = 0; k < 20 && !done; k++) @(negedge clk);
        chk("R10", int'(line_vals), 'h02, "busy ignores loads");
        run_and_wait();
        chk("R10", int'(cost), 3, "list unchanged by busy load");
        chk("R10", int'(line_vals), 'h00, "second run");

        repeat (3) @(negedge clk);
        report();
    end

endmodule